// File: doc/BRIEF.md
# Phase Slope Limiter with Lock Detect

This block sits between the phase detector and the loop filter of a telecom digital PLL. Once per 125 µs frame the phase detector presents a signed phase-error word with a one-cycle strobe. The block registers the word and forwards it to the loop filter, together with a one-cycle valid pulse.

In normal mode the forwarded value is clamped so that the recovered phase cannot slew faster than 5 ns per frame. In fast-lock mode the clamp is bypassed so that acquisition is quicker. A registered flag shows whether the latest sample was clamped.

A lock flag is raised once the frequency-match qualifier has been true on a run of consecutive samples, and each of those samples was small enough that the slope bound did not bind. The first sample that breaks the run drops the flag again.

Top module: `phase_slope_limiter`

## Requirements
- R1: A sample is taken on each clock where `err_valid` is high. `err_out` and `out_valid` update on the next rising edge. `out_valid` is high for exactly one cycle per accepted sample.
- R2: The error word is two's complement at 0.1 ns per LSB. With `fast_lock` low, the forwarded value is the input clamped to the range -50..+50 (±5 ns). A value inside that range, including -50 and +50 themselves, is forwarded unchanged.
- R3: With `fast_lock` high, the input word is forwarded unchanged for any value, including the most negative and most positive codes.
- R4: `limiting` is set by a sample whose value was changed by the clamp. It is cleared by a sample that was not changed. It keeps its value between samples. A sample taken in fast-lock mode always clears it.
- R5: A sample qualifies when `freq_match` is high and the input magnitude is at most 50 LSB, in either mode. `lock` rises together with the `out_valid` of the 16th consecutive qualifying sample, and stays high while samples keep qualifying.
- R6: A single non-qualifying sample drops `lock` and restarts the run count from zero.
- R7: Changes on `err_in`, `fast_lock` or `freq_match` without a strobe have no effect on `err_out`, `limiting` or `lock`.
- R8: A synchronous active-high `rst` clears `err_out`, `out_valid`, `limiting`, `lock` and the run count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| err_valid | input | 1 | Sample strobe, once per frame |
| err_in | input | ERR_W | Signed phase error, 0.1 ns per LSB |
| fast_lock | input | 1 | 1 = bypass the slope clamp |
| freq_match | input | 1 | Frequency-match qualifier |
| err_out | output | ERR_W | Registered, limited error to the loop filter |
| out_valid | output | 1 | One-cycle pulse with each new `err_out` |
| limiting | output | 1 | Last sample was altered by the clamp |
| lock | output | 1 | Lock indication |

## Verification
The only hidden state is the run counter. A wrong count shows at the ports as `lock` rising one or more samples early or late on the 16th qualifying sample, or failing to restart after a broken run. That is visible within one frame of the fault. A wrong clamp comparison shows on the next strobe as `err_out` off at the ±50 boundary or at the extreme codes, with `limiting` disagreeing. Stale or strobe-ignoring registers show as `err_out` or `limiting` moving on a cycle without a strobe.

// File: rtl/phase_slope_limiter.sv
module phase_slope_limiter #(
  parameter int ERR_W    = 16,
  parameter int LIMIT    = 50,
  parameter int LOCK_RUN = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    err_valid,
  input  logic signed [ERR_W-1:0] err_in,
  input  logic                    fast_lock,
  input  logic                    freq_match,
  output logic signed [ERR_W-1:0] err_out,
  output logic                    out_valid,
  output logic                    limiting,
  output logic                    lock
);
  localparam int CNT_W = $clog2(LOCK_RUN + 1);
  localparam logic signed [ERR_W-1:0] POS_LIM = ERR_W'(LIMIT);
  localparam logic signed [ERR_W-1:0] NEG_LIM = -POS_LIM;
  localparam logic [CNT_W-1:0] RUN_LAST = CNT_W'(LOCK_RUN - 1);
  localparam logic [CNT_W-1:0] RUN_MAX  = CNT_W'(LOCK_RUN);

  logic                    above, below, over, clip, qual;
  logic signed [ERR_W-1:0] clamped;
  logic [CNT_W-1:0]        run_cnt;

  assign above   = err_in > POS_LIM;
  assign below   = err_in < NEG_LIM;
  assign over    = above | below;
  assign clip    = over & ~fast_lock;
  assign qual    = freq_match & ~over;
  assign clamped = above ? POS_LIM : (below ? NEG_LIM : err_in);

  always_ff @(posedge clk) begin
    if (rst) begin
      err_out   <= '0;
      out_valid <= 1'b0;
      limiting  <= 1'b0;
    end else begin
      out_valid <= err_valid;
      if (err_valid) begin
        err_out  <= fast_lock ? err_in : clamped;
        limiting <= clip;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= '0;
      lock    <= 1'b0;
    end else if (err_valid) begin
      if (!qual) begin
        run_cnt <= '0;
        lock    <= 1'b0;
      end else begin
        if (run_cnt != RUN_MAX) run_cnt <= run_cnt + 1'b1;
        lock <= (run_cnt >= RUN_LAST);
      end
    end
  end
endmodule

// File: rtl/phase_slope_limiter_sva.sv
module phase_slope_limiter_sva #(
  parameter int ERR_W = 16,
  parameter int LIMIT = 50
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    err_valid,
  input logic signed [ERR_W-1:0] err_in,
  input logic                    fast_lock,
  input logic                    freq_match,
  input logic signed [ERR_W-1:0] err_out,
  input logic                    out_valid,
  input logic                    limiting,
  input logic                    lock
);
  localparam logic signed [ERR_W-1:0] POS_LIM = ERR_W'(LIMIT);
  localparam logic signed [ERR_W-1:0] NEG_LIM = -POS_LIM;

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_valid == $past(err_valid)));

  a_r2_bound: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !$past(fast_lock)) |-> (err_out <= POS_LIM && err_out >= NEG_LIM));

  a_r3_passthru: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(fast_lock)) |-> (err_out == $past(err_in) && !limiting));

  a_r5_lock_needs_match: assert property (@(posedge clk) disable iff (rst)
    $rose(lock) |-> $past(freq_match));

  a_r5_lock_not_limiting: assert property (@(posedge clk) disable iff (rst)
    lock |-> !limiting);

  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(err_valid)) |-> ($stable(err_out) && $stable(limiting) && $stable(lock)));

  a_r8_reset: assert property (@(posedge clk)
    $past(rst) |-> (!lock && !out_valid && !limiting && err_out == '0));
endmodule

bind phase_slope_limiter phase_slope_limiter_sva #(.ERR_W(ERR_W), .LIMIT(LIMIT)) u_sva (
  .clk(clk), .rst(rst), .err_valid(err_valid), .err_in(err_in),
  .fast_lock(fast_lock), .freq_match(freq_match), .err_out(err_out),
  .out_valid(out_valid), .limiting(limiting), .lock(lock)
);

// File: tb/phase_slope_limiter_tb.sv
module phase_slope_limiter_tb;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic err_valid = 1'b0;
  logic signed [W-1:0] err_in = '0;
  logic fast_lock = 1'b0;
  logic freq_match = 1'b0;
  logic signed [W-1:0] err_out;
  logic out_valid, limiting, lock;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  phase_slope_limiter u_dut (
    .clk(clk), .rst(rst), .err_valid(err_valid), .err_in(err_in),
    .fast_lock(fast_lock), .freq_match(freq_match), .err_out(err_out),
    .out_valid(out_valid), .limiting(limiting), .lock(lock)
  );

  // behavioural reference
  int m_out = 0;
  bit m_vld = 0, m_lim = 0, m_lock = 0;
  int m_run = 0;
  bit started = 0;

  always @(posedge clk) begin
    int v;
    started <= 1'b1;
    if (rst) begin
      m_out <= 0; m_vld <= 0; m_lim <= 0; m_lock <= 0; m_run <= 0;
    end else begin
      m_vld <= err_valid;
      if (err_valid) begin
        v = int'(err_in);
        if (fast_lock) m_out <= v;
        else m_out <= (v > 50) ? 50 : ((v < -50) ? -50 : v);
        m_lim <= !fast_lock && (v > 50 || v < -50);
        if (freq_match && v <= 50 && v >= -50) begin
          m_run <= m_run + 1;
          m_lock <= (m_run + 1 >= 16);
        end else begin
          m_run <= 0;
          m_lock <= 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      checks += 4;
      if (int'(err_out) != m_out) begin
        failures++;
        $display("FAIL R2/R3 err_out actual=%0d expected=%0d t=%0t", err_out, m_out, $time);
      end
      if (out_valid != m_vld) begin
        failures++;
        $display("FAIL R1 out_valid actual=%0b expected=%0b t=%0t", out_valid, m_vld, $time);
      end
      if (limiting != m_lim) begin
        failures++;
        $display("FAIL R4 limiting actual=%0b expected=%0b t=%0t", limiting, m_lim, $time);
      end
      if (lock != m_lock) begin
        failures++;
        $display("FAIL R5/R6 lock actual=%0b expected=%0b t=%0t", lock, m_lock, $time);
      end
    end
  end

  task automatic send(input int val, input bit fl, input bit fm, input int gap);
    @(negedge clk);
    err_in = W'(val); fast_lock = fl; freq_match = fm; err_valid = 1'b1;
    @(negedge clk);
    err_valid = 1'b0;
    // R7: wiggle inputs without strobe
    for (int i = 0; i < gap; i++) begin
      err_in = W'(val * 7 + i * 1234);
      fast_lock = ~fast_lock;
      freq_match = ~freq_match;
      @(negedge clk);
    end
  endtask

  initial begin
    int lfsr;
    lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    rst = 1'b0;                       // R8 reset state checked above
    // R2 in-range and boundaries
    send(0, 0, 1, 2);
    send(50, 0, 1, 1);
    send(-50, 0, 1, 1);
    send(51, 0, 1, 2);                // R4 set
    send(-51, 0, 1, 3);
    send(32767, 0, 1, 0);
    send(-32768, 0, 1, 0);
    send(12, 0, 1, 1);                // R4 clear
    send(-300, 0, 1, 0);
    // R3 fast-lock passthrough
    send(-32768, 1, 1, 1);
    send(32767, 1, 0, 1);
    send(999, 1, 1, 0);
    // R5 lock run of 20
    for (int i = 0; i < 20; i++) send((i % 101) - 50, i[0], 1, i % 3);
    // R6 break by freq_match
    send(3, 0, 0, 1);
    for (int i = 0; i < 17; i++) send(i, 0, 1, 0);
    // R6 break by oversize in fast-lock
    send(400, 1, 1, 1);
    for (int i = 0; i < 15; i++) send(-i, 1, 1, 0);
    send(51, 0, 1, 0);
    // R8 mid-run reset
    for (int i = 0; i < 18; i++) send(5, 0, 1, 0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 16; i++) send(-5, 0, 1, 0);
    // mixed pattern
    for (int i = 0; i < 400; i++) begin
      lfsr = ((lfsr >> 1) ^ ((lfsr & 1) ? 16'hB400 : 0)) & 16'hFFFF;
      send((lfsr % 3 == 0) ? (lfsr - 32768) : ((lfsr % 121) - 60),
           (lfsr % 7) == 0, (lfsr % 11) != 0, lfsr % 2);
    end
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule